// File: doc/BRIEF.md
# Open-Row-First DRAM Read Scheduler

This block sits between a cache's miss path and one DRAM channel with a single rank. It accepts read requests (a physical address and a tag), holds them in a small age-ordered queue, and decides which one goes to memory next. When it chooses, it picks a request whose row is already open in its bank. If no queued request hits an open row, it picks the oldest request whose bank can take it.

Each address is cut into fields. The low bits select a byte within a 64-byte line. The next bits give the column, then the bank, and the remaining high bits give the row. The block keeps the open row of each bank and leaves it open after every access. It models how long each bank stays busy: a short time for a row hit, and a long time for a row conflict or an access to a closed row. Banks work at the same time as each other. Issues from the block are spaced apart by a fixed minimum gap. Each bank reports when its access completes and returns the tag of the request it served.

Top module: `frfcfs_sched`

## Requirements
- R1: An address splits as follows. Bits [5:0] are the line offset and are not decoded. Bits [COL_W+5:6] are the column. The next BANK_W bits are the bank. All higher bits are the row. `issueBank` shows the bank field of the issued request, and `issueAddr` shows its full address unchanged.
- R2: After reset every bank has no open row. The first access to any bank reports `issueHit`=0 and takes the conflict latency.
- R3: A row hit completes exactly HIT_LAT (50) cycles after its issue pulse. A row conflict or closed-row access completes exactly MISS_LAT (250) cycles after its issue pulse. Completion is a one-cycle pulse on `doneVec[bank]`, with the tag on slice `doneTags[bank*TAG_W +: TAG_W]`.
- R4: At most one request issues per cycle. Two issue pulses are always at least ISSUE_GAP (10) cycles apart.
- R5: When a request can issue, one that hits its bank's open row is chosen before an older request that does not.
- R6: Among eligible row hits, the oldest goes first. When no row hit is eligible, the oldest eligible request goes first.
- R7: A request is held while its bank is busy. Requests to other banks still issue during that time. A bank can take a new request in the same cycle its completion is reported.
- R8: After an access, its row stays open. A later request to the same row, even at a different column, is a hit. A request to a different row of that bank is a conflict.
- R9: `reqReady` is low while QDEPTH requests are queued. A request offered while `reqReady` is low is dropped and never issues.
- R10: During and right after reset, `reqReady`=1, `issueValid`=0 and `doneVec`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Enqueue request valid |
| reqAddr | input | ADDR_W | Physical address of the read |
| reqTag | input | TAG_W | Requester tag |
| reqReady | output | 1 | Queue can accept a request |
| issueValid | output | 1 | One-cycle pulse: a request was sent to DRAM |
| issueAddr | output | ADDR_W | Address of the issued request |
| issueTag | output | TAG_W | Tag of the issued request |
| issueBank | output | BANK_W | Bank field of the issued request |
| issueHit | output | 1 | Issued request hit the open row |
| doneVec | output | 2**BANK_W | Per-bank completion pulse |
| doneTags | output | 2**BANK_W*TAG_W | Per-bank tag of the completed request |

## Verification
Two pairs of events can land in the same cycle. In the first, one bank reports a completion while a row hit waiting on that same bank is issued. The bench sets this up by queuing an older conflict and a younger hit behind a busy bank. It then checks three things: the completion cycle, that the younger hit issues in exactly that cycle, and that both tags come out correctly. In the second, an enqueue and a dequeue happen on the same edge. The bench offers a new request at the exact edge where the only queued request issues. It then checks that the newcomer keeps its place in age order and later issues on time.

// File: rtl/frfcfs_pkg.sv
package frfcfs_pkg;
  // strobes from control to datapath for one clock edge
  typedef struct packed {
    logic issue;  // dequeue the picked entry and start its bank
    logic hit;    // picked entry matches its bank's open row
    logic enq;    // accept the request on the enqueue port
  } ctlStrobe_t;
endpackage

// File: rtl/frfcfs_dp.sv
module frfcfs_dp
  import frfcfs_pkg::*;
#(
  parameter int QDEPTH   = 4,
  parameter int ADDR_W   = 32,
  parameter int TAG_W    = 4,
  parameter int BANK_W   = 2,
  parameter int COL_W    = 6,
  parameter int OFF_W    = 6,
  parameter int HIT_LAT  = 50,
  parameter int MISS_LAT = 250,
  localparam int NBANK   = 1 << BANK_W,
  localparam int ROW_LSB = OFF_W + COL_W + BANK_W,
  localparam int ROW_W   = ADDR_W - ROW_LSB,
  localparam int IDX_W   = $clog2(QDEPTH),
  localparam int CNT_W   = $clog2(MISS_LAT + 1)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [ADDR_W-1:0]                 reqAddr,
  input  logic [TAG_W-1:0]                  reqTag,
  input  ctlStrobe_t                        strobe,
  input  logic [IDX_W-1:0]                  pickIdx,
  output logic [QDEPTH-1:0]                 entValid,
  output logic [QDEPTH-1:0][BANK_W-1:0]     entBank,
  output logic [QDEPTH-1:0][ROW_W-1:0]      entRow,
  output logic [NBANK-1:0]                  bankFree,
  output logic [NBANK-1:0]                  openValid,
  output logic [NBANK-1:0][ROW_W-1:0]       openRow,
  output logic                              issueValid,
  output logic [ADDR_W-1:0]                 issueAddr,
  output logic [TAG_W-1:0]                  issueTag,
  output logic [BANK_W-1:0]                 issueBank,
  output logic                              issueHit,
  output logic [NBANK-1:0]                  doneVec,
  output logic [NBANK*TAG_W-1:0]            doneTags
);

  logic [QDEPTH-1:0]              qValid, nValid;
  logic [QDEPTH-1:0][ADDR_W-1:0]  qAddr, nAddr;
  logic [QDEPTH-1:0][TAG_W-1:0]   qTag, nTag;

  logic [ADDR_W-1:0] pickAddr;
  logic [TAG_W-1:0]  pickTag;
  logic [BANK_W-1:0] pickBank;

  assign pickAddr = qAddr[pickIdx];
  assign pickTag  = qTag[pickIdx];
  assign pickBank = pickAddr[OFF_W+COL_W +: BANK_W];

  // field view of each queue slot
  for (genvar i = 0; i < QDEPTH; i++) begin : g_view
    assign entValid[i] = qValid[i];
    assign entBank[i]  = qAddr[i][OFF_W+COL_W +: BANK_W];
    assign entRow[i]   = qAddr[i][ADDR_W-1:ROW_LSB];
  end

  // collapse on dequeue, append on enqueue; slot 0 is always the oldest
  always_comb begin
    int occ;
    nValid = qValid;
    nAddr  = qAddr;
    nTag   = qTag;
    for (int i = 0; i < QDEPTH; i++) begin
      if (strobe.issue && i >= int'(pickIdx)) begin
        if (i < QDEPTH - 1) begin
          nValid[i] = qValid[i+1];
          nAddr[i]  = qAddr[i+1];
          nTag[i]   = qTag[i+1];
        end else begin
          nValid[i] = 1'b0;
        end
      end
    end
    occ = $countones(qValid) - (strobe.issue ? 1 : 0);
    for (int i = 0; i < QDEPTH; i++) begin
      if (strobe.enq && i == occ) begin
        nValid[i] = 1'b1;
        nAddr[i]  = reqAddr;
        nTag[i]   = reqTag;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      qValid <= '0;
      qAddr  <= '0;
      qTag   <= '0;
    end else begin
      qValid <= nValid;
      qAddr  <= nAddr;
      qTag   <= nTag;
    end
  end

  // issue pulse register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      issueValid <= 1'b0;
      issueAddr  <= '0;
      issueTag   <= '0;
      issueBank  <= '0;
      issueHit   <= 1'b0;
    end else begin
      issueValid <= strobe.issue;
      issueHit   <= strobe.issue && strobe.hit;
      if (strobe.issue) begin
        issueAddr <= pickAddr;
        issueTag  <= pickTag;
        issueBank <= pickBank;
      end
    end
  end

  // per-bank open row and occupancy timer
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [CNT_W-1:0] busyCnt;
    logic [TAG_W-1:0] curTag;
    logic             startHere;

    assign startHere   = strobe.issue && (pickBank == BANK_W'(b));
    assign bankFree[b] = (busyCnt <= CNT_W'(1));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        busyCnt      <= '0;
        curTag       <= '0;
        openValid[b] <= 1'b0;
        openRow[b]   <= '0;
        doneVec[b]   <= 1'b0;
        doneTags[b*TAG_W +: TAG_W] <= '0;
      end else begin
        doneVec[b] <= (busyCnt == CNT_W'(1));
        if (busyCnt == CNT_W'(1)) doneTags[b*TAG_W +: TAG_W] <= curTag;
        if (startHere) begin
          busyCnt      <= strobe.hit ? CNT_W'(HIT_LAT) : CNT_W'(MISS_LAT);
          curTag       <= pickTag;
          openValid[b] <= 1'b1;
          openRow[b]   <= pickAddr[ADDR_W-1:ROW_LSB];
        end else if (busyCnt != '0) begin
          busyCnt <= busyCnt - CNT_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/frfcfs_ctl.sv
module frfcfs_ctl
  import frfcfs_pkg::*;
#(
  parameter int QDEPTH    = 4,
  parameter int BANK_W    = 2,
  parameter int ROW_W     = 18,
  parameter int ISSUE_GAP = 10,
  localparam int NBANK    = 1 << BANK_W,
  localparam int IDX_W    = $clog2(QDEPTH),
  localparam int GAP_W    = $clog2(ISSUE_GAP + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          reqValid,
  input  logic [QDEPTH-1:0]             entValid,
  input  logic [QDEPTH-1:0][BANK_W-1:0] entBank,
  input  logic [QDEPTH-1:0][ROW_W-1:0]  entRow,
  input  logic [NBANK-1:0]              bankFree,
  input  logic [NBANK-1:0]              openValid,
  input  logic [NBANK-1:0][ROW_W-1:0]   openRow,
  output ctlStrobe_t                    strobe,
  output logic [IDX_W-1:0]              pickIdx,
  output logic                          reqReady
);

  logic [GAP_W-1:0]  gapCnt;
  logic              gapOk;
  logic [QDEPTH-1:0] elig, hitElig;
  logic              anyElig, anyHit;
  logic [IDX_W-1:0]  eligIdx, hitIdx;

  assign gapOk = (gapCnt <= GAP_W'(1));

  for (genvar i = 0; i < QDEPTH; i++) begin : g_elig
    assign elig[i]    = entValid[i] && bankFree[entBank[i]] && gapOk;
    assign hitElig[i] = elig[i] && openValid[entBank[i]] &&
                        (openRow[entBank[i]] == entRow[i]);
  end

  // lowest slot index is oldest; scan from the young end so the oldest wins
  always_comb begin
    anyElig = 1'b0;
    anyHit  = 1'b0;
    eligIdx = '0;
    hitIdx  = '0;
    for (int i = QDEPTH - 1; i >= 0; i--) begin
      if (elig[i]) begin
        anyElig = 1'b1;
        eligIdx = IDX_W'(i);
      end
      if (hitElig[i]) begin
        anyHit = 1'b1;
        hitIdx = IDX_W'(i);
      end
    end
  end

  assign pickIdx      = anyHit ? hitIdx : eligIdx;
  assign reqReady     = ~&entValid;
  assign strobe.issue = anyElig;
  assign strobe.hit   = anyHit;
  assign strobe.enq   = reqValid && reqReady;

  always_ff @(posedge clk) begin
    if (!rst_n)            gapCnt <= '0;
    else if (anyElig)      gapCnt <= GAP_W'(ISSUE_GAP);
    else if (gapCnt != '0) gapCnt <= gapCnt - GAP_W'(1);
  end

endmodule

// File: rtl/frfcfs_sched.sv
module frfcfs_sched
  import frfcfs_pkg::*;
#(
  parameter int QDEPTH    = 4,
  parameter int ADDR_W    = 32,
  parameter int TAG_W     = 4,
  parameter int BANK_W    = 2,
  parameter int COL_W     = 6,
  parameter int HIT_LAT   = 50,
  parameter int MISS_LAT  = 250,
  parameter int ISSUE_GAP = 10,
  localparam int OFF_W    = 6,
  localparam int NBANK    = 1 << BANK_W,
  localparam int ROW_W    = ADDR_W - OFF_W - COL_W - BANK_W,
  localparam int IDX_W    = $clog2(QDEPTH)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reqValid,
  input  logic [ADDR_W-1:0]      reqAddr,
  input  logic [TAG_W-1:0]       reqTag,
  output logic                   reqReady,
  output logic                   issueValid,
  output logic [ADDR_W-1:0]      issueAddr,
  output logic [TAG_W-1:0]       issueTag,
  output logic [BANK_W-1:0]      issueBank,
  output logic                   issueHit,
  output logic [NBANK-1:0]       doneVec,
  output logic [NBANK*TAG_W-1:0] doneTags
);

  ctlStrobe_t                    strobe;
  logic [IDX_W-1:0]              pickIdx;
  logic [QDEPTH-1:0]             entValid;
  logic [QDEPTH-1:0][BANK_W-1:0] entBank;
  logic [QDEPTH-1:0][ROW_W-1:0]  entRow;
  logic [NBANK-1:0]              bankFree;
  logic [NBANK-1:0]              openValid;
  logic [NBANK-1:0][ROW_W-1:0]   openRow;

  frfcfs_ctl #(
    .QDEPTH(QDEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W), .ISSUE_GAP(ISSUE_GAP)
  ) u_ctl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid),
    .entValid(entValid), .entBank(entBank), .entRow(entRow),
    .bankFree(bankFree), .openValid(openValid), .openRow(openRow),
    .strobe(strobe), .pickIdx(pickIdx), .reqReady(reqReady)
  );

  frfcfs_dp #(
    .QDEPTH(QDEPTH), .ADDR_W(ADDR_W), .TAG_W(TAG_W), .BANK_W(BANK_W),
    .COL_W(COL_W), .OFF_W(OFF_W), .HIT_LAT(HIT_LAT), .MISS_LAT(MISS_LAT)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .reqAddr(reqAddr), .reqTag(reqTag),
    .strobe(strobe), .pickIdx(pickIdx),
    .entValid(entValid), .entBank(entBank), .entRow(entRow),
    .bankFree(bankFree), .openValid(openValid), .openRow(openRow),
    .issueValid(issueValid), .issueAddr(issueAddr), .issueTag(issueTag),
    .issueBank(issueBank), .issueHit(issueHit),
    .doneVec(doneVec), .doneTags(doneTags)
  );

endmodule

// File: rtl/frfcfs_sched_chk.sv
module frfcfs_sched_chk #(
  parameter int BANK_W    = 2,
  parameter int HIT_LAT   = 50,
  parameter int MISS_LAT  = 250,
  parameter int ISSUE_GAP = 10,
  localparam int NBANK    = 1 << BANK_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              issueValid,
  input logic [BANK_W-1:0] issueBank,
  input logic              issueHit,
  input logic [NBANK-1:0]  doneVec
);

  logic [15:0]            sinceIssue;
  logic [NBANK-1:0][15:0] sinceBank;
  logic [NBANK-1:0][15:0] lastLat;
  logic [NBANK-1:0]       outstanding;
  logic [NBANK-1:0]       touched;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sinceIssue  <= 16'hFFFF;
      sinceBank   <= '0;
      lastLat     <= '0;
      outstanding <= '0;
      touched     <= '0;
    end else begin
      if (issueValid) sinceIssue <= 16'd1;
      else if (sinceIssue != 16'hFFFF) sinceIssue <= sinceIssue + 16'd1;
      for (int b = 0; b < NBANK; b++) begin
        if (issueValid && issueBank == BANK_W'(b)) begin
          sinceBank[b]   <= 16'd1;
          lastLat[b]     <= issueHit ? 16'(HIT_LAT) : 16'(MISS_LAT);
          outstanding[b] <= 1'b1;
          touched[b]     <= 1'b1;
        end else begin
          if (sinceBank[b] != 16'hFFFF) sinceBank[b] <= sinceBank[b] + 16'd1;
          if (doneVec[b]) outstanding[b] <= 1'b0;
        end
      end
    end
  end

  assert_issue_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    issueValid |-> sinceIssue >= 16'(ISSUE_GAP));

  assert_cold_bank_miss_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (issueValid && !touched[issueBank]) |-> !issueHit);

  assert_bank_not_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    issueValid |-> (!outstanding[issueBank] ||
                    sinceBank[issueBank] >= lastLat[issueBank]));

  for (genvar b = 0; b < NBANK; b++) begin : g_done
    assert_done_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
      doneVec[b] |-> (outstanding[b] && sinceBank[b] == lastLat[b]));
  end

endmodule

bind frfcfs_sched frfcfs_sched_chk #(
  .BANK_W(BANK_W), .HIT_LAT(HIT_LAT), .MISS_LAT(MISS_LAT), .ISSUE_GAP(ISSUE_GAP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .issueValid(issueValid), .issueBank(issueBank),
  .issueHit(issueHit), .doneVec(doneVec)
);

// File: tb/frfcfs_sched_tb.sv
module frfcfs_sched_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TAG_W = 4;
  localparam int BANK_W = 2;
  localparam int NBANK = 4;
  localparam int HIT = 50;
  localparam int MISS = 250;

  logic clk = 0, rst_n = 0;
  logic reqValid = 0;
  logic [31:0] reqAddr = '0;
  logic [TAG_W-1:0] reqTag = '0;
  logic reqReady, issueValid, issueHit;
  logic [31:0] issueAddr;
  logic [TAG_W-1:0] issueTag;
  logic [BANK_W-1:0] issueBank;
  logic [NBANK-1:0] doneVec;
  logic [NBANK*TAG_W-1:0] doneTags;

  frfcfs_sched u_dut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqTag(reqTag), .reqReady(reqReady), .issueValid(issueValid),
    .issueAddr(issueAddr), .issueTag(issueTag), .issueBank(issueBank),
    .issueHit(issueHit), .doneVec(doneVec), .doneTags(doneTags)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  int nChk = 0, nFail = 0;
  int iN = 0, dN = 0;
  int iTag[64], iHit[64], iBank[64], iCyc[64];
  logic [31:0] iAddr[64];
  int dTag[64], dCyc[64];

  always @(posedge clk) cyc <= cyc + 1;

  // monitor samples at the falling edge
  always @(negedge clk) if (rst_n) begin
    if (issueValid && iN < 64) begin
      iTag[iN] = int'(issueTag); iHit[iN] = int'(issueHit);
      iBank[iN] = int'(issueBank); iCyc[iN] = cyc; iAddr[iN] = issueAddr;
      iN++;
    end
    for (int b = 0; b < NBANK; b++)
      if (doneVec[b] && dN < 64) begin
        dTag[dN] = int'(doneTags[b*TAG_W +: TAG_W]); dCyc[dN] = cyc; dN++;
      end
  end

  function automatic logic [31:0] mkAddr(int row, int bank, int col, int off);
    return (32'(row) << 14) | (32'(bank) << 12) | (32'(col) << 6) | 32'(off);
  endfunction

  function automatic int doneAt(int tag);
    for (int k = dN - 1; k >= 0; k--) if (dTag[k] == tag) return dCyc[k];
    return -1;
  endfunction

  function automatic int issueCount(int tag, int from);
    int n = 0;
    for (int k = from; k < iN; k++) if (iTag[k] == tag) n++;
    return n;
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic enq(int row, int bank, int col, int off, int tag);
    @(negedge clk);
    reqValid = 1; reqAddr = mkAddr(row, bank, col, off); reqTag = TAG_W'(tag);
    @(negedge clk);
    reqValid = 0;
  endtask

  // check issue slot k: tag, hit flag, bank, and offset from a reference cycle
  task automatic chkIssue(string req, int k, int tag, int hit, int bank,
                          int refCyc, int delta);
    chk(req, $sformatf("slot%0d tag", k), iTag[k], tag);
    chk(req, $sformatf("tag%0d hit", tag), iHit[k], hit);
    chk("R1", $sformatf("tag%0d bank", tag), iBank[k], bank);
    chk(req, $sformatf("tag%0d issue cycle", tag), iCyc[k] - refCyc, delta);
    chk("R3", $sformatf("tag%0d done latency", tag), doneAt(tag) - iCyc[k],
        hit ? HIT : MISS);
  endtask

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog (all): actual hung expected finished");
    report();
    $finish;
  end

  initial begin
    int b0;
    int t0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state while held
    chk("R10", "ready in reset", reqReady, 1);
    chk("R10", "issue in reset", issueValid, 0);
    chk("R10", "done in reset", doneVec, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R10", "ready after reset", reqReady, 1);
    chk("R10", "issue after reset", issueValid, 0);

    // Scenario 1: older conflict vs younger hit behind a busy bank (R5, R7, R8)
    b0 = iN;
    enq(0, 0, 0, 0, 1);            // A: bank0 row0, cold
    enq(1, 0, 0, 0, 3);            // C: bank0 row1, conflict later
    enq(0, 0, 1, 21, 4);           // D: bank0 row0 col1, hit later
    enq(5, 1, 0, 0, 2);            // B: bank1, parallel
    repeat (700) @(posedge clk);
    chk("R4", "scenario1 issues", iN - b0, 4);
    t0 = iCyc[b0];
    chkIssue("R2", b0 + 0, 1, 0, 0, t0, 0);
    chkIssue("R7", b0 + 1, 2, 0, 1, t0, ISSUE_GAP_C);
    chkIssue("R5", b0 + 2, 4, 1, 0, t0, MISS);
    chkIssue("R8", b0 + 3, 3, 0, 0, t0, MISS + HIT);
    chk("R7", "A done same cycle as D issue", doneAt(1), iCyc[b0 + 2]);
    chk("R1", "D address unchanged", iAddr[b0 + 2], mkAddr(0, 0, 1, 21));

    // Scenario 2: enqueue during dequeue, gap, oldest-first (R4, R6)
    b0 = iN;
    @(negedge clk);
    reqValid = 1; reqAddr = mkAddr(2, 2, 0, 0); reqTag = 5;       // P
    @(negedge clk);
    reqAddr = mkAddr(3, 3, 0, 0); reqTag = 6;                      // Q, same edge as P issue
    @(negedge clk);
    reqAddr = mkAddr(9, 1, 0, 0); reqTag = 7;                      // S, bank1 conflict
    @(negedge clk);
    reqValid = 0;
    repeat (30) @(negedge clk);
    enq(4, 2, 0, 0, 8);            // M: bank2 conflict, oldest of three
    enq(2, 2, 5, 0, 9);            // H1: hit
    enq(2, 2, 9, 3, 10);           // H2: hit
    repeat (700) @(posedge clk);
    chk("R4", "scenario2 issues", iN - b0, 6);
    t0 = iCyc[b0];
    chkIssue("R2", b0 + 0, 5, 0, 2, t0, 0);
    chkIssue("R6", b0 + 1, 6, 0, 3, t0, ISSUE_GAP_C);
    chkIssue("R4", b0 + 2, 7, 0, 1, t0, 2 * ISSUE_GAP_C);
    chkIssue("R6", b0 + 3, 9, 1, 2, t0, MISS);
    chkIssue("R6", b0 + 4, 10, 1, 2, t0, MISS + HIT);
    chkIssue("R8", b0 + 5, 8, 0, 2, t0, MISS + 2 * HIT);

    // Scenario 3: full queue drops offered request (R9)
    b0 = iN;
    enq(20, 0, 0, 0, 11);
    enq(21, 0, 0, 0, 12);
    enq(22, 0, 0, 0, 13);
    enq(23, 0, 0, 0, 14);
    enq(24, 0, 0, 0, 15);
    @(negedge clk);
    chk("R9", "ready low when full", reqReady, 0);
    reqValid = 1; reqAddr = mkAddr(30, 2, 0, 0); reqTag = 0;
    repeat (5) @(negedge clk);
    chk("R9", "ready still low", reqReady, 0);
    reqValid = 0;
    repeat (1400) @(posedge clk);
    @(negedge clk);
    chk("R9", "ready back after drain", reqReady, 1);
    chk("R9", "dropped request never issued", issueCount(0, b0), 0);
    chk("R9", "scenario3 issues", iN - b0, 5);
    t0 = iCyc[b0];
    for (int k = 0; k < 5; k++)
      chkIssue("R6", b0 + k, 11 + k, 0, 0, t0, k * MISS);

    report();
    $finish;
  end

  localparam int ISSUE_GAP_C = 10;
endmodule